// File: doc/BRIEF.md
# DMA Channel Address and Count Register File

This block keeps the working state of a four-channel DMA engine. Each channel has a start address and a transfer length. Each of these exists twice: a base copy that only the CPU loads, and a current copy that moves while data is transferred. The CPU writes the 16-bit values one byte at a time through a small write-only register port. A byte pointer selects whether each byte lands in the lower or upper half of the register.

While a transfer runs, the central controller sends one `step` pulse per completed transfer cycle for the channel on `sel`. The current address then moves by one, up or down as the channel's mode chooses, and the current count drops by one. When a step finds the count already at zero, the count wraps to all ones and the block raises terminal count. An external end-of-process pulse also closes the transfer. A closing channel that has auto-initialize enabled reloads its current copies from the base copies and stays armed. A closing channel without auto-initialize masks itself.

Control and status pins are plain level signals with no handshake. No data stream passes through this block, so there is no valid/ready interface and no back-pressure to define. The current address and count of the selected channel are always visible, together with the per-channel mask and terminal-count flags.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, all address and count registers read 0, every mask bit is 1, every terminal-count status bit is 0, and the byte pointer points at the low byte.
- R2: A CPU write with `cpu_addr[3]`=0 targets channel `cpu_addr[2:1]`. It writes the address register when `cpu_addr[0]`=0 and the count register when `cpu_addr[0]`=1. The byte goes into bits 7:0 when the pointer is low and into bits 15:8 when it is high, and it updates the base and current copies together. Each such write toggles the pointer. A write to command 1 (`cpu_addr`=0x9) returns the pointer to low.
- R3: A step on an enabled channel adds 1 to its current address, or subtracts 1 when mode bit 3 is set. A mode write is command 0 (`cpu_addr`=0x8), with data bits [1:0] giving the channel, bit 2 auto-initialize, bit 3 decrement and bits [5:4] the transfer kind: 00 single, 01 block, 10 cascade.
- R4: A step on an enabled channel subtracts 1 from its current count. If the count was 0x0000, then `tc` is 1 combinationally in that cycle, the count becomes 0xFFFF, and the channel's `tc_status` bit is set from the next edge.
- R5: On terminal count with auto-initialize off, the channel's mask bit becomes 1.
- R6: On terminal count with auto-initialize on, the current address and count reload from their base copies and the mask bit stays 0.
- R7: An `eop` pulse on an enabled channel closes the transfer without touching `tc_status`. It reloads the current copies when auto-initialize is on and sets the mask bit when it is off.
- R8: `step` and `eop` have no effect on a channel that is masked or programmed as cascade, and `tc` stays 0 for such a channel.
- R9: Command 2 (`cpu_addr`=0xA) sets the mask bit of channel `data[1:0]` when `data[2]`=1 and clears it when `data[2]`=0. Command 3 (`cpu_addr`=0xB) clears every `tc_status` bit whose `data` bit is 1.
- R10: Stepping one channel leaves the registers, mask and status of every other channel unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr | input | 1 | CPU write strobe, one byte per cycle |
| cpu_addr | input | 4 | CPU register select (channel registers or command) |
| cpu_wdata | input | 8 | CPU write byte |
| sel | input | 2 | Channel targeted by step and eop, and shown on the outputs |
| step | input | 1 | One transfer cycle completed on channel `sel` |
| eop | input | 1 | External end-of-process for channel `sel` |
| cur_addr | output | 16 | Current address of channel `sel` |
| cur_count | output | 16 | Current count of channel `sel` |
| tc | output | 1 | Terminal count, combinational with the final step |
| tc_status | output | 4 | Sticky terminal-count flags, one per channel |
| mask | output | 4 | Per-channel mask bits |

## Verification
`tc` is a combinational result of `step`, `sel` and the stored count, so it is due in the same cycle as the step. The bench reads it 2 ns after driving inputs on the falling edge, well before the next rising edge. Every stored result (address, count, mask, status and pointer) appears one rising edge after its stimulus, so the bench reads those 2 ns after that edge, before the next stimulus is driven. Ignored stimulus is checked the same way: the bench confirms that address, count and mask still hold their old values one edge later.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;

  // Transfer kind carried in the mode byte, bits [5:4]
  typedef enum logic [1:0] {
    XFER_SINGLE  = 2'b00,
    XFER_BLOCK   = 2'b01,
    XFER_CASCADE = 2'b10,
    XFER_RSVD    = 2'b11
  } xfer_kind_e;

  typedef struct packed {
    logic       autoinit;
    logic       decr;
    xfer_kind_e kind;
  } chan_mode_t;

  // Command codes inside the command region
  localparam logic [1:0] CMD_MODE   = 2'd0;
  localparam logic [1:0] CMD_PTRCLR = 2'd1;
  localparam logic [1:0] CMD_MASK   = 2'd2;
  localparam logic [1:0] CMD_TCCLR  = 2'd3;

  // Field positions inside command data bytes
  localparam int MODE_AUTO_BIT = 2;
  localparam int MODE_DECR_BIT = 3;
  localparam int MODE_KIND_LSB = 4;
  localparam int MASK_SET_BIT  = 2;

  function automatic chan_mode_t decode_mode(input logic [7:0] b);
    chan_mode_t m;
    m.autoinit = b[MODE_AUTO_BIT];
    m.decr     = b[MODE_DECR_BIT];
    m.kind     = xfer_kind_e'(b[MODE_KIND_LSB +: 2]);
    return m;
  endfunction

endpackage

// File: rtl/dma_cpu_decode.sv
module dma_cpu_decode
  import dma_regs_pkg::*;
#(
  parameter  int NCH    = 4,
  localparam int CHW    = $clog2(NCH),
  localparam int CPU_AW = CHW + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [7:0]        cpu_wdata,
  output logic              wr_hi,
  output logic [NCH-1:0]    addr_we,
  output logic [NCH-1:0]    cnt_we,
  output logic [NCH-1:0]    mode_we,
  output chan_mode_t        mode_val,
  output logic [NCH-1:0]    mask_set,
  output logic [NCH-1:0]    mask_clr,
  output logic [NCH-1:0]    tc_clr
);

  logic           ptr_q;
  logic           reg_hit;
  logic           cmd_hit;
  logic [1:0]     cmd;
  logic [CHW-1:0] reg_ch;
  logic [CHW-1:0] cmd_ch;

  assign reg_hit  = cpu_wr && !cpu_addr[CPU_AW-1];
  assign cmd_hit  = cpu_wr &&  cpu_addr[CPU_AW-1];
  assign cmd      = cpu_addr[1:0];
  assign reg_ch   = cpu_addr[CHW:1];
  assign cmd_ch   = cpu_wdata[CHW-1:0];
  assign wr_hi    = ptr_q;
  assign mode_val = decode_mode(cpu_wdata);

  // Byte pointer: low byte first, toggles per register write
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ptr_q <= 1'b0;
    end else if (cmd_hit && cmd == CMD_PTRCLR) begin
      ptr_q <= 1'b0;
    end else if (reg_hit) begin
      ptr_q <= !ptr_q;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_dec
    assign addr_we[i]  = reg_hit && reg_ch == CHW'(i) && !cpu_addr[0];
    assign cnt_we[i]   = reg_hit && reg_ch == CHW'(i) &&  cpu_addr[0];
    assign mode_we[i]  = cmd_hit && cmd == CMD_MODE && cmd_ch == CHW'(i);
    assign mask_set[i] = cmd_hit && cmd == CMD_MASK && cmd_ch == CHW'(i)
                         &&  cpu_wdata[MASK_SET_BIT];
    assign mask_clr[i] = cmd_hit && cmd == CMD_MASK && cmd_ch == CHW'(i)
                         && !cpu_wdata[MASK_SET_BIT];
    assign tc_clr[i]   = cmd_hit && cmd == CMD_TCCLR && cpu_wdata[i];
  end

endmodule

// File: rtl/dma_chan_slot.sv
module dma_chan_slot
  import dma_regs_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_hi,
  input  logic [7:0]    wbyte,
  input  logic          addr_we,
  input  logic          cnt_we,
  input  logic          mode_we,
  input  chan_mode_t    mode_in,
  input  logic          mask_set,
  input  logic          mask_clr,
  input  logic          tc_clr,
  input  logic          step,
  input  logic          eop,
  output logic [AW-1:0] cur_addr,
  output logic [AW-1:0] cur_cnt,
  output logic          tc,
  output logic          mask,
  output logic          tc_stat
);

  localparam int HW = AW - 8;

  logic [AW-1:0] base_addr, base_cnt;
  logic [AW-1:0] addr_q, cnt_q;
  logic [AW-1:0] addr_nxt;
  chan_mode_t    mode_q;
  logic          mask_q, stat_q;
  logic          active, go, close_x, done, reload;

  assign active   = !mask_q && mode_q.kind != XFER_CASCADE;
  assign go       = step && active;
  assign close_x  = eop && active;
  assign tc       = go && cnt_q == '0;
  assign done     = tc || close_x;
  assign reload   = done && mode_q.autoinit;
  assign addr_nxt = mode_q.decr ? addr_q - AW'(1) : addr_q + AW'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_addr <= '0;
      addr_q    <= '0;
    end else if (addr_we) begin
      if (wr_hi) begin
        base_addr[AW-1:8] <= wbyte[HW-1:0];
        addr_q[AW-1:8]    <= wbyte[HW-1:0];
      end else begin
        base_addr[7:0] <= wbyte;
        addr_q[7:0]    <= wbyte;
      end
    end else if (reload) begin
      addr_q <= base_addr;
    end else if (go) begin
      addr_q <= addr_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_cnt <= '0;
      cnt_q    <= '0;
    end else if (cnt_we) begin
      if (wr_hi) begin
        base_cnt[AW-1:8] <= wbyte[HW-1:0];
        cnt_q[AW-1:8]    <= wbyte[HW-1:0];
      end else begin
        base_cnt[7:0] <= wbyte;
        cnt_q[7:0]    <= wbyte;
      end
    end else if (reload) begin
      cnt_q <= base_cnt;
    end else if (go) begin
      cnt_q <= cnt_q - AW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '{autoinit: 1'b0, decr: 1'b0, kind: XFER_SINGLE};
      mask_q <= 1'b1;
      stat_q <= 1'b0;
    end else begin
      if (mode_we) mode_q <= mode_in;
      if (mask_set)                          mask_q <= 1'b1;
      else if (mask_clr)                     mask_q <= 1'b0;
      else if (done && !mode_q.autoinit)     mask_q <= 1'b1;
      if (tc)          stat_q <= 1'b1;
      else if (tc_clr) stat_q <= 1'b0;
    end
  end

  assign cur_addr = addr_q;
  assign cur_cnt  = cnt_q;
  assign mask     = mask_q;
  assign tc_stat  = stat_q;

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regs_pkg::*;
#(
  parameter  int NCH    = 4,
  parameter  int AW     = 16,
  localparam int CHW    = $clog2(NCH),
  localparam int CPU_AW = CHW + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_wr,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [7:0]        cpu_wdata,
  input  logic [CHW-1:0]    sel,
  input  logic              step,
  input  logic              eop,
  output logic [AW-1:0]     cur_addr,
  output logic [AW-1:0]     cur_count,
  output logic              tc,
  output logic [NCH-1:0]    tc_status,
  output logic [NCH-1:0]    mask
);

  logic             wr_hi;
  logic [NCH-1:0]   addr_we, cnt_we, mode_we;
  logic [NCH-1:0]   mask_set, mask_clr, tc_clr;
  chan_mode_t       mode_val;
  logic [AW-1:0]    ch_addr [NCH];
  logic [AW-1:0]    ch_cnt  [NCH];
  logic [NCH-1:0]   ch_tc;

  dma_cpu_decode #(.NCH(NCH)) u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .cpu_wr   (cpu_wr),
    .cpu_addr (cpu_addr),
    .cpu_wdata(cpu_wdata),
    .wr_hi    (wr_hi),
    .addr_we  (addr_we),
    .cnt_we   (cnt_we),
    .mode_we  (mode_we),
    .mode_val (mode_val),
    .mask_set (mask_set),
    .mask_clr (mask_clr),
    .tc_clr   (tc_clr)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic hit;
    assign hit = sel == CHW'(i);

    dma_chan_slot #(.AW(AW)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_hi   (wr_hi),
      .wbyte   (cpu_wdata),
      .addr_we (addr_we[i]),
      .cnt_we  (cnt_we[i]),
      .mode_we (mode_we[i]),
      .mode_in (mode_val),
      .mask_set(mask_set[i]),
      .mask_clr(mask_clr[i]),
      .tc_clr  (tc_clr[i]),
      .step    (step && hit),
      .eop     (eop && hit),
      .cur_addr(ch_addr[i]),
      .cur_cnt (ch_cnt[i]),
      .tc      (ch_tc[i]),
      .mask    (mask[i]),
      .tc_stat (tc_status[i])
    );
  end

  assign cur_addr  = ch_addr[sel];
  assign cur_count = ch_cnt[sel];
  assign tc        = |ch_tc;

endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk #(
  parameter  int NCH = 4,
  parameter  int AW  = 16,
  localparam int CHW = $clog2(NCH)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cpu_wr,
  input logic [CHW-1:0] sel,
  input logic           step,
  input logic [AW-1:0]  cur_addr,
  input logic           tc,
  input logic [NCH-1:0] tc_status,
  input logic [NCH-1:0] mask
);

  // R4: terminal count only comes with a step
  p_tc_needs_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tc |-> step);

  // R4: terminal count leaves the channel's status flag set
  p_tc_sets_status_r4: assert property (@(posedge clk) disable iff (!rst_n)
    tc |=> tc_status[$past(sel)]);

  // R8: a masked channel never signals terminal count
  p_masked_no_tc_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mask[sel] |-> !tc);

  // R8: a masked channel's address does not move without a CPU write
  p_masked_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!cpu_wr && mask[sel]) ##1 (sel == $past(sel)) |-> cur_addr == $past(cur_addr));

  for (genvar i = 0; i < NCH; i++) begin : g_bit
    // R9: a status flag clears only after a CPU write
    p_status_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tc_status[i]) |-> $past(cpu_wr));
    // R4: a status flag rises only after terminal count on that channel
    p_status_source_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tc_status[i]) |-> $past(tc && sel == CHW'(i)));
  end

endmodule

bind dma_chan_regs dma_chan_regs_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cpu_wr   (cpu_wr),
  .sel      (sel),
  .step     (step),
  .cur_addr (cur_addr),
  .tc       (tc),
  .tc_status(tc_status),
  .mask     (mask)
);

// File: tb/sim_dma_chan_regs.sv
`timescale 1ns/1ps
module sim_dma_chan_regs;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_wr = 1'b0;
  logic [3:0]  cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic [1:0]  sel = '0;
  logic        step = 1'b0;
  logic        eop = 1'b0;
  logic [15:0] cur_addr, cur_count;
  logic        tc;
  logic [3:0]  tc_status, mask;

  int  n_checks = 0;
  int  n_errors = 0;
  bit  finished = 1'b0;
  logic seen_tc;

  always #10 clk = ~clk;  // 50 MHz

  dma_chan_regs u0 (
    .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .sel(sel), .step(step), .eop(eop),
    .cur_addr(cur_addr), .cur_count(cur_count), .tc(tc),
    .tc_status(tc_status), .mask(mask)
  );

  typedef struct packed {
    logic        w;
    logic [3:0]  a;
    logic [7:0]  d;
    logic [1:0]  s;
    logic        st;
    logic        e;
    logic        xtc;
    logic [15:0] xaddr;
    logic [15:0] xcnt;
    logic [3:0]  xmask;
    logic [3:0]  xtcs;
    logic [7:0]  req;
  } vec_t;

  // Channel 0 sequence; each row is one cycle
  localparam vec_t VT [18] = '{
    '{1'b1, 4'h0, 8'h34, 2'd0, 1'b0, 1'b0, 1'b0, 16'h0034, 16'h0000, 4'hF, 4'h0, 8'd2}, // R2 low byte
    '{1'b1, 4'h0, 8'h12, 2'd0, 1'b0, 1'b0, 1'b0, 16'h1234, 16'h0000, 4'hF, 4'h0, 8'd2}, // R2 high byte
    '{1'b1, 4'h1, 8'h02, 2'd0, 1'b0, 1'b0, 1'b0, 16'h1234, 16'h0002, 4'hF, 4'h0, 8'd2},
    '{1'b1, 4'h1, 8'h00, 2'd0, 1'b0, 1'b0, 1'b0, 16'h1234, 16'h0002, 4'hF, 4'h0, 8'd2},
    '{1'b0, 4'h0, 8'h00, 2'd0, 1'b1, 1'b0, 1'b0, 16'h1234, 16'h0002, 4'hF, 4'h0, 8'd8}, // R8 masked step
    '{1'b1, 4'hA, 8'h00, 2'd0, 1'b0, 1'b0, 1'b0, 16'h1234, 16'h0002, 4'hE, 4'h0, 8'd9}, // R9 unmask
    '{1'b1, 4'h8, 8'h00, 2'd0, 1'b0, 1'b0, 1'b0, 16'h1234, 16'h0002, 4'hE, 4'h0, 8'd3},
    '{1'b0, 4'h0, 8'h00, 2'd0, 1'b1, 1'b0, 1'b0, 16'h1235, 16'h0001, 4'hE, 4'h0, 8'd3}, // R3 up
    '{1'b0, 4'h0, 8'h00, 2'd0, 1'b1, 1'b0, 1'b0, 16'h1236, 16'h0000, 4'hE, 4'h0, 8'd4},
    '{1'b0, 4'h0, 8'h00, 2'd0, 1'b1, 1'b0, 1'b1, 16'h1237, 16'hFFFF, 4'hF, 4'h1, 8'd5}, // R4 R5
    '{1'b1, 4'hB, 8'h01, 2'd0, 1'b0, 1'b0, 1'b0, 16'h1237, 16'hFFFF, 4'hF, 4'h0, 8'd9}, // R9 clear
    '{1'b1, 4'h8, 8'h0C, 2'd0, 1'b0, 1'b0, 1'b0, 16'h1237, 16'hFFFF, 4'hF, 4'h0, 8'd6},
    '{1'b1, 4'hA, 8'h00, 2'd0, 1'b0, 1'b0, 1'b0, 16'h1237, 16'hFFFF, 4'hE, 4'h0, 8'd9},
    '{1'b0, 4'h0, 8'h00, 2'd0, 1'b1, 1'b0, 1'b0, 16'h1236, 16'hFFFE, 4'hE, 4'h0, 8'd3}, // R3 down
    '{1'b0, 4'h0, 8'h00, 2'd0, 1'b0, 1'b1, 1'b0, 16'h1234, 16'h0002, 4'hE, 4'h0, 8'd7}, // R7 reload
    '{1'b0, 4'h0, 8'h00, 2'd0, 1'b1, 1'b0, 1'b0, 16'h1233, 16'h0001, 4'hE, 4'h0, 8'd3},
    '{1'b0, 4'h0, 8'h00, 2'd0, 1'b1, 1'b0, 1'b0, 16'h1232, 16'h0000, 4'hE, 4'h0, 8'd3},
    '{1'b0, 4'h0, 8'h00, 2'd0, 1'b1, 1'b0, 1'b1, 16'h1234, 16'h0002, 4'hE, 4'h1, 8'd6}  // R6 reload
  };

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // Drive at the falling edge, sample tc mid-phase, registers after the edge
  task automatic cyc(input logic w, input logic [3:0] a, input logic [7:0] d,
                     input logic [1:0] s, input logic st, input logic e);
    @(negedge clk);
    cpu_wr = w; cpu_addr = a; cpu_wdata = d; sel = s; step = st; eop = e;
    #2 seen_tc = tc;
    @(posedge clk);
    #2;
    cpu_wr = 1'b0; step = 1'b0; eop = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual hung expected done");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1", "cur_addr", cur_addr, 0);
    check("R1", "cur_count", cur_count, 0);
    check("R1", "mask", mask, 4'hF);
    check("R1", "tc_status", tc_status, 0);
    check("R1", "tc", tc, 0);

    for (int i = 0; i < 18; i++) begin
      string r;
      r = $sformatf("R%0d/v%0d", VT[i].req, i);
      cyc(VT[i].w, VT[i].a, VT[i].d, VT[i].s, VT[i].st, VT[i].e);
      check(r, "tc", seen_tc, VT[i].xtc);
      check(r, "cur_addr", cur_addr, VT[i].xaddr);
      check(r, "cur_count", cur_count, VT[i].xcnt);
      check(r, "mask", mask, VT[i].xmask);
      check(r, "tc_status", tc_status, VT[i].xtcs);
    end

    // R2 pointer clear: ch1 address, stray low byte then clear
    cyc(1'b1, 4'h2, 8'hAA, 2'd1, 1'b0, 1'b0);
    cyc(1'b1, 4'h9, 8'h00, 2'd1, 1'b0, 1'b0);
    cyc(1'b1, 4'h2, 8'hBB, 2'd1, 1'b0, 1'b0);
    cyc(1'b1, 4'h2, 8'hCC, 2'd1, 1'b0, 1'b0);
    check("R2", "ptr clear addr", cur_addr, 16'hCCBB);

    // R8 cascade channel ignores step
    cyc(1'b1, 4'h8, 8'h21, 2'd1, 1'b0, 1'b0);
    cyc(1'b1, 4'hA, 8'h01, 2'd1, 1'b0, 1'b0);
    check("R9", "unmask ch1", mask, 4'hC);
    cyc(1'b0, 4'h0, 8'h00, 2'd1, 1'b1, 1'b0);
    check("R8", "cascade tc", seen_tc, 0);
    check("R8", "cascade addr", cur_addr, 16'hCCBB);

    // R7 eop without auto-initialize masks the channel
    cyc(1'b1, 4'h8, 8'h01, 2'd1, 1'b0, 1'b0);
    cyc(1'b0, 4'h0, 8'h00, 2'd1, 1'b0, 1'b1);
    check("R7", "eop mask", mask, 4'hE);
    check("R7", "eop status", tc_status, 4'h1);
    check("R7", "eop addr", cur_addr, 16'hCCBB);

    // R10 channel 2 underflow leaves channel 0 alone
    cyc(1'b1, 4'h5, 8'h00, 2'd2, 1'b0, 1'b0);
    cyc(1'b1, 4'h5, 8'h00, 2'd2, 1'b0, 1'b0);
    cyc(1'b1, 4'hA, 8'h02, 2'd2, 1'b0, 1'b0);
    cyc(1'b0, 4'h0, 8'h00, 2'd2, 1'b1, 1'b0);
    check("R4", "ch2 tc", seen_tc, 1);
    check("R4", "ch2 count", cur_count, 16'hFFFF);
    check("R5", "ch2 mask", mask, 4'hE);
    check("R10", "status", tc_status, 4'h5);
    sel = 2'd0;
    #1;
    check("R10", "ch0 addr", cur_addr, 16'h1234);
    check("R10", "ch0 count", cur_count, 16'h0002);

    // R9 mask set by command
    cyc(1'b1, 4'hA, 8'h04, 2'd0, 1'b0, 1'b0);
    check("R9", "mask set", mask, 4'hF);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

endmodule